// File: doc/BRIEF.md
# Interrupt Eligibility and Priority Selector

This block looks at the interrupt lines that are pending, the per-line enable mask and the per-line delegation mask. It also takes the hart's current privilege level and the two global interrupt-enable bits, one for machine level and one for supervisor level. From these it decides whether an interrupt must be taken now and which one. Each line is routed to one of two groups by its delegation bit. A line whose delegation bit is clear belongs to the machine group. A line whose delegation bit is set belongs to the supervisor group. Each group is gated by its own privilege rule, and the surviving lines from both groups are merged. The merged vector goes to a lowest-index-first picker.

The block produces a take strobe, the winning line index, and a cause word. The cause word has its top bit set to mark an interrupt and carries the index in its low bits. An elaboration parameter chooses between two output modes: outputs driven straight from the logic, or outputs held in one register stage. The register width (32 or 64) is also a parameter. Trap entry, register storage and the interrupt sources themselves are handled elsewhere.

Top module: `irq_select_arb`

## Requirements
- R1: A line can be chosen only when both its pending bit and its enable bit are 1. A pending line with enable 0 never produces a take.
- R2: The privilege code on `priv_i` is 0 for user, 1 for supervisor and 3 for machine. A line whose delegation bit is 0 is eligible at user or supervisor level regardless of the global enables. At machine level it is eligible only while `m_gie_i` is 1.
- R3: A line whose delegation bit is 1 is eligible at user level regardless of the global enables. At supervisor level it is eligible only while `s_gie_i` is 1. At machine level it is never eligible.
- R4: The eligible set is the union of the lines that pass the R2 gate and the lines that pass the R3 gate. The take strobe is 1 exactly when this set is non-empty.
- R5: When several lines are eligible, `index_o` reports the lowest-numbered eligible line. This includes line XLEN-1 when it is the only eligible line.
- R6: While the take strobe is 1, `cause_o` has bit XLEN-1 set to 1, has bits [log2(XLEN)-1:0] equal to `index_o`, and has all other bits 0.
- R7: While no line is eligible, `take_o` is 0 and both `index_o` and `cause_o` are all zeros.
- R8: With REG_OUT=1 (the default), every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| pend_i | input | XLEN | Pending interrupt lines |
| enab_i | input | XLEN | Per-line enable mask |
| deleg_i | input | XLEN | Per-line delegation to supervisor level |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| index_o | output | log2(XLEN) | Index of the winning line |
| cause_o | output | XLEN | Cause word: top bit set, index in low bits |

## Verification
The bench covers the following corner cases, and what a wrong design would do in each:
- **Machine level with its global enable clear.** Non-delegated lines must be blocked. A design that ignores the privilege comparison would take them anyway.
- **Machine level with delegated lines pending.** Delegated lines must never be taken there. A design that applies the supervisor enable to them would wrongly let them through.
- **Mixed delegation masks at supervisor level.** With the supervisor enable clear, only the machine-group lines may survive. A design that merges the two groups before gating would pick the wrong line.
- **Priority order.** Stimulus places several eligible lines at once, and also places only the top line. A picker that scans the wrong way, or truncates the index, then reports a wrong index or cause.

Randomised sweeps over all legal privilege levels and both enables compare every cycle against a behavioural model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Privilege encoding used by the current-level input.
  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_MACH  = 2'd3
  } priv_e;

  // True when the hart runs strictly below the given level.
  function automatic logic below_level(input logic [1:0] cur, input priv_e lvl);
    return cur < lvl;
  endfunction

  // Level gate: below the level always open, at the level only with the enable.
  function automatic logic level_open(input logic [1:0] cur, input priv_e lvl,
                                      input logic gie);
    return below_level(cur, lvl) || ((cur == lvl) && gie);
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pend,
  input  logic [XLEN-1:0] enab,
  input  logic [XLEN-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            m_gie,
  input  logic            s_gie,
  output logic [XLEN-1:0] cand,
  output logic [XLEN-1:0] elig_m,
  output logic [XLEN-1:0] elig_s,
  output logic [XLEN-1:0] elig
);

  logic m_open;
  logic s_open;

  assign m_open = level_open(priv, PRV_MACH, m_gie);
  assign s_open = level_open(priv, PRV_SUPER, s_gie);

  assign cand   = pend & enab;
  assign elig_m = cand & ~deleg & {XLEN{m_open}};
  assign elig_s = cand &  deleg & {XLEN{s_open}};
  assign elig   = elig_m | elig_s;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int XLEN = 64,
  parameter int IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] elig,
  output logic            any,
  output logic [IDXW-1:0] idx
);

  // Downward scan: the last hit written is the lowest set bit.
  function automatic logic [IDXW-1:0] lowest_set(input logic [XLEN-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  assign any = |elig;
  assign idx = any ? lowest_set(elig) : '0;

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int XLEN    = 64,
  parameter int IDXW    = $clog2(XLEN),
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any,
  input  logic [IDXW-1:0] idx,
  output logic            take,
  output logic [IDXW-1:0] index,
  output logic [XLEN-1:0] cause
);

  function automatic logic [XLEN-1:0] make_cause(input logic hit,
                                                 input logic [IDXW-1:0] n);
    logic [XLEN-1:0] c;
    c = '0;
    if (hit) begin
      c[XLEN-1]   = 1'b1;
      c[IDXW-1:0] = n;
    end
    return c;
  endfunction

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          take  <= 1'b0;
          index <= '0;
          cause <= '0;
        end else begin
          take  <= any;
          index <= idx;
          cause <= make_cause(any, idx);
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign take  = any;
      assign index = idx;
      assign cause = make_cause(any, idx);
    end
  endgenerate

endmodule

// File: rtl/irq_select_arb.sv
module irq_select_arb
  import irq_arb_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int IDXW   = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] enab_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  output logic            take_o,
  output logic [IDXW-1:0] index_o,
  output logic [XLEN-1:0] cause_o
);

  logic [XLEN-1:0] w_cand;
  logic [XLEN-1:0] w_elig_m;
  logic [XLEN-1:0] w_elig_s;
  logic [XLEN-1:0] w_elig;
  logic            w_any;
  logic [IDXW-1:0] w_idx;
  logic [XLEN-1:0] w_below_win;

  irq_gate #(.XLEN(XLEN)) u_gate (
    .pend   (pend_i),
    .enab   (enab_i),
    .deleg  (deleg_i),
    .priv   (priv_i),
    .m_gie  (m_gie_i),
    .s_gie  (s_gie_i),
    .cand   (w_cand),
    .elig_m (w_elig_m),
    .elig_s (w_elig_s),
    .elig   (w_elig)
  );

  // Gate checks: each group obeys its own level rule.
  a_r1_cand_only: assert property (@(posedge clk) disable iff (!rst_n)
    (w_elig & ~(pend_i & enab_i)) == '0);
  a_r2_mach_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRV_MACH && !m_gie_i) |-> (w_elig_m == '0));
  a_r3_deleg_off_in_m: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRV_MACH) |-> (w_elig_s == '0));
  a_r3_user_open: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRV_USER) |-> (w_elig_s == (w_cand & deleg_i)));

  irq_pick #(.XLEN(XLEN), .IDXW(IDXW)) u_pick (
    .elig (w_elig),
    .any  (w_any),
    .idx  (w_idx)
  );

  assign w_below_win = (XLEN'(1) << w_idx) - XLEN'(1);

  // Picker check: winner is eligible and nothing below it is.
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    w_any |-> (w_elig[w_idx] && ((w_elig & w_below_win) == '0)));

  irq_out_stage #(.XLEN(XLEN), .IDXW(IDXW), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .any   (w_any),
    .idx   (w_idx),
    .take  (take_o),
    .index (index_o),
    .cause (cause_o)
  );

  // Output checks.
  a_r6_cause_form: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cause_o[XLEN-1] && cause_o[IDXW-1:0] == index_o &&
                $countones(cause_o) == 1 + $countones(index_o)));
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0 && index_o == '0));

  generate
    if (REG_OUT) begin : g_lat_chk
      a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (take_o == $past(w_any) && index_o == $past(w_idx)));
    end
  endgenerate

endmodule

// File: tb/tb_irq_select_arb.sv
module tb_irq_select_arb;

  localparam int XLEN     = 64;
  localparam int IDXW     = $clog2(XLEN);
  localparam time CLK_PER = 10ns;
  localparam int MAX_CYC  = 20000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [XLEN-1:0] pend, enab, deleg;
  logic [1:0]      priv;
  logic            mg, sg;
  logic            take_o;
  logic [IDXW-1:0] index_o;
  logic [XLEN-1:0] cause_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PER / 2) clk = ~clk;

  irq_select_arb #(.XLEN(XLEN)) dut (
    .clk (clk), .rst_n (rst_n),
    .pend_i (pend), .enab_i (enab), .deleg_i (deleg),
    .priv_i (priv), .m_gie_i (mg), .s_gie_i (sg),
    .take_o (take_o), .index_o (index_o), .cause_o (cause_o)
  );

  // Behavioural reference: walk the lines upward, apply the rules per line.
  function automatic void ref_model(input logic [XLEN-1:0] p, e, d,
                                    input int pr, input bit m, s,
                                    output bit tk, output int win);
    tk  = 0;
    win = 0;
    for (int i = 0; i < XLEN; i++) begin
      bit ok;
      if (d[i]) ok = (pr == 0) || (pr == 1 && s);
      else      ok = (pr != 3) || m;
      if (p[i] && e[i] && ok && !tk) begin
        tk  = 1;
        win = i;
      end
    end
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive inputs at a falling edge, let one rising edge register them,
  // compare at the next falling edge.
  task automatic drive(input logic [XLEN-1:0] p, e, d, input int pr,
                       input bit m, s, input string tag);
    bit tk;
    int win;
    logic [XLEN-1:0] exp_cause;
    pend = p; enab = e; deleg = d; priv = 2'(pr); mg = m; sg = s;
    ref_model(p, e, d, pr, m, s, tk, win);
    exp_cause = '0;
    if (tk) exp_cause = (XLEN'(1) << (XLEN - 1)) | XLEN'(win);
    @(negedge clk);
    chk(tag, "take",  XLEN'(take_o),  XLEN'(tk));
    chk(tag, "index", XLEN'(index_o), XLEN'(win));
    chk(tag, "cause", cause_o,        exp_cause);
  endtask

  function automatic int rand_priv();
    int r;
    r = int'($urandom_range(0, 2));
    return (r == 2) ? 3 : r;
  endfunction

  initial begin
    rst_n = 1'b0;
    pend = '1; enab = '1; deleg = '0; priv = 2'd0; mg = 1; sg = 1;
    @(negedge clk);
    @(negedge clk);
    // R8: held in reset, outputs are zero despite eligible lines.
    chk("R8", "reset take",  XLEN'(take_o),  '0);
    chk("R8", "reset index", XLEN'(index_o), '0);
    chk("R8", "reset cause", cause_o,        '0);
    rst_n = 1'b1;

    // R1: masked by enable.
    drive('1, '0, '0, 3, 1, 1, "R1");
    drive(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0020, '0, 3, 1, 1, "R1");
    // R2: machine group.
    drive(64'h88, 64'hFF, '0, 3, 0, 1, "R2");
    drive(64'h88, 64'hFF, '0, 3, 1, 0, "R2");
    drive(64'h88, 64'hFF, '0, 1, 0, 0, "R2");
    drive(64'h88, 64'hFF, '0, 0, 0, 0, "R2");
    // R3: supervisor group.
    drive(64'h30, 64'hFF, '1, 3, 1, 1, "R3");
    drive(64'h30, 64'hFF, '1, 1, 1, 0, "R3");
    drive(64'h30, 64'hFF, '1, 1, 0, 1, "R3");
    drive(64'h30, 64'hFF, '1, 0, 0, 0, "R3");
    // R4: mixed masks, supervisor enable clear keeps only machine lines.
    drive(64'h0F, 64'h0F, 64'h03, 1, 0, 0, "R4");
    drive(64'h0F, 64'h0F, 64'h0C, 3, 1, 0, "R4");
    drive(64'h0F, 64'h0F, 64'h0C, 3, 0, 1, "R4");
    // R5: lowest wins, and the top line alone.
    drive(64'hF000_0000_0001_0100, '1, '0, 0, 0, 0, "R5");
    drive(64'h8000_0000_0000_0000, '1, '1, 0, 0, 0, "R5");
    drive(64'h8000_0000_0000_0000, '1, '0, 3, 1, 0, "R5");
    // R6: cause form with a mid index.
    drive(64'h0000_0400_0000_0000, '1, '0, 1, 0, 0, "R6");
    // R7: nothing pending.
    drive('0, '1, '0, 0, 1, 1, "R7");

    // R4 sweep: all levels and enables, random vectors.
    for (int n = 0; n < 400; n++) begin
      logic [XLEN-1:0] rp, re, rd;
      rp = {$urandom, $urandom} & {$urandom, $urandom};
      re = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      drive(rp, re, rd, rand_priv(), 1'($urandom), 1'($urandom), "R4");
    end

    // R8: reset clears the outputs again.
    rst_n = 1'b0;
    pend = '1; enab = '1; priv = 2'd0;
    @(negedge clk);
    chk("R8", "re-reset take", XLEN'(take_o), '0);
    chk("R8", "re-reset cause", cause_o, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule